// File: doc/BRIEF.md
# One-Hot Integer ALU

This block is the combinational arithmetic and logic unit for a simple in-order RISC pipeline. Each cycle the execute stage gives it a one-hot operation select and two data operands, and it returns one result of the same width in the same cycle. It holds no state. The operands are chosen outside the block: operand A is either the PC or a register, and operand B is either an immediate or a register.

The supported operations are:

- addition, which also covers immediate add, load and store address generation, and return-address computation (PC plus the constant 4);
- subtraction;
- signed and unsigned less-than compares;
- four bitwise operations: AND, NOR, OR and XOR;
- three shifts: left logical, right logical and right arithmetic;
- a pass-through of operand B for upper-immediate loads. Operand B already holds the immediate in its upper 20 bits with 12 zero bits below.

Addition, subtraction and both compares share one carry chain. All three shift kinds share one logarithmic right shifter.

Top module: `onehot_alu`

## Requirements
- R1: When select bit 0 alone is set, the result is A + B modulo 2^32. With A set to a PC value and B set to 4, this gives the return address PC + 4.
- R2: When select bit 1 alone is set, the result is A - B in two's complement, modulo 2^32.
- R3: When select bit 2 alone is set, the result is 32'd1 if A is less than B as signed numbers, and 32'd0 otherwise.
- R4: When select bit 3 alone is set, the result is 32'd1 if A is less than B as unsigned numbers, and 32'd0 otherwise.
- R5: The bitwise operations use these select bits: bit 4 gives A AND B, bit 5 gives NOT (A OR B), bit 6 gives A OR B, and bit 7 gives A XOR B.
- R6: When select bit 8 alone is set, the result is A shifted left by B[4:0], with zeros shifted in.
- R7: When select bit 9 alone is set, the result is A shifted right by B[4:0], with zeros shifted in at the top.
- R8: When select bit 10 alone is set, the result is A shifted right by B[4:0], with each vacated bit filled with A[31].
- R9: For all three shifts, only B[4:0] sets the shift amount. B[31:5] has no effect on the result.
- R10: When select bit 11 alone is set, the result equals B unchanged.
- R11: When no select bit is set, the result is 32'h0.
- R12: The result follows the inputs within the same cycle; there is no register between input and output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 12 | One-hot operation select (bit order as in R1 to R11) |
| src_a | input | 32 | Operand A (register or PC) |
| src_b | input | 32 | Operand B (register or immediate; shift amount in [4:0]) |
| result | output | 32 | Operation result |

## Verification
The bench aims at the points where a shared carry chain or a shared shifter tends to go wrong:

- **Signed compare.** It uses operands of opposite sign where the difference overflows, such as 0x80000000 against 1. A design that simply takes the sign bit of the difference reports these the wrong way round.
- **Unsigned compare.** It uses equal operands and values with the top bit set. A misread carry-out makes equal values appear less than each other.
- **Shift amounts.** It shifts by 0 and by 31, and it sets junk in B[31:5]. A design that decodes the shift amount too widely returns zero or a wrongly shifted value.
- **Arithmetic versus logical right shift.** It shifts negative and positive values right both ways. A design that swaps or drops the fill bit shows it in the upper bits.
- **Wrap-around.** It checks add and subtract results that wrap past 2^32.
- **Empty select.** It checks that an all-zero select gives zero and does not leak the output of any operation.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int XLEN = 32;
  localparam int OP_N = 12;

  // Select bit positions; the decoder upstream depends on this order.
  localparam int OP_ADD  = 0;
  localparam int OP_SUB  = 1;
  localparam int OP_SLT  = 2;
  localparam int OP_SLTU = 3;
  localparam int OP_AND  = 4;
  localparam int OP_NOR  = 5;
  localparam int OP_OR   = 6;
  localparam int OP_XOR  = 7;
  localparam int OP_SLL  = 8;
  localparam int OP_SRL  = 9;
  localparam int OP_SRA  = 10;
  localparam int OP_LUI  = 11;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = alu_pkg::XLEN
) (
  input  logic              sub_mode,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sum,
  output logic              lt_signed,
  output logic              lt_unsigned
);
  localparam int MSB = DATA_W - 1;

  // One carry chain: a + (b or ~b) + carry_in, carry out in the top bit.
  function automatic logic [DATA_W:0] add_ci(input logic [DATA_W-1:0] x,
                                             input logic [DATA_W-1:0] y,
                                             input logic              ci);
    return {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, ci};
  endfunction

  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   chain;
  logic              carry_out;
  logic              sign_differs;

  assign b_eff        = sub_mode ? ~b : b;
  assign chain        = add_ci(a, b_eff, sub_mode);
  assign sum          = chain[MSB:0];
  assign carry_out    = chain[DATA_W];
  assign sign_differs = a[MSB] ^ b[MSB];
  // Signed: when signs differ the negative operand is smaller; else use the difference sign.
  assign lt_signed    = sign_differs ? a[MSB] : sum[MSB];
  // Unsigned: no carry out of a + ~b + 1 means a < b.
  assign lt_unsigned  = ~carry_out;

  always_comb begin
    if (sub_mode && (a == b)) begin
      a_r4_equal_not_less: assert (!lt_signed && !lt_unsigned && (sum == '0))
        else $error("equal operands reported as less");
    end
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int DATA_W = alu_pkg::XLEN
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] and_r,
  output logic [DATA_W-1:0] nor_r,
  output logic [DATA_W-1:0] or_r,
  output logic [DATA_W-1:0] xor_r
);
  assign and_r = a & b;
  assign or_r  = a | b;
  assign xor_r = a ^ b;
  assign nor_r = ~or_r;

  always_comb begin
    a_r5_xor_and_partition: assert (((and_r & xor_r) == '0) && ((and_r | xor_r) == or_r))
      else $error("bitwise results inconsistent");
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int DATA_W = alu_pkg::XLEN,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a,
  input  logic [SH_W-1:0]   shamt,
  input  logic              dir_left,
  input  logic              arith,
  output logic [DATA_W-1:0] shifted
);
  localparam int MSB = DATA_W - 1;

  function automatic logic [DATA_W-1:0] bit_reverse(input logic [DATA_W-1:0] x);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = x[MSB-i];
    return r;
  endfunction

  logic [DATA_W-1:0] stage [SH_W+1];
  logic              fill;

  // Left shifts run through the right shifter on a bit-reversed operand.
  assign stage[0] = dir_left ? bit_reverse(a) : a;
  assign fill     = arith & ~dir_left & a[MSB];

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = shamt[k] ? {{STEP{fill}}, stage[k][MSB:STEP]} : stage[k];
  end

  assign shifted = dir_left ? bit_reverse(stage[SH_W]) : stage[SH_W];

  always_comb begin
    if (shamt == '0) begin
      a_r6_zero_shift_identity: assert (shifted == a)
        else $error("zero shift altered operand");
    end
    if (!dir_left && arith && a[MSB]) begin
      a_r8_sign_fill: assert (shifted[MSB])
        else $error("arithmetic shift lost sign");
    end
    if (!dir_left && !arith && (shamt != '0)) begin
      a_r7_zero_fill: assert (!shifted[MSB])
        else $error("logical right shift filled with one");
    end
  end
endmodule

// File: rtl/alu_result_mux.sv
module alu_result_mux #(
  parameter int DATA_W = alu_pkg::XLEN,
  parameter int OP_N   = alu_pkg::OP_N
) (
  input  logic [OP_N-1:0]              sel,
  input  logic [OP_N-1:0][DATA_W-1:0]  cand,
  output logic [DATA_W-1:0]            out
);
  logic [OP_N-1:0][DATA_W-1:0] masked;

  for (genvar i = 0; i < OP_N; i++) begin : g_mask
    assign masked[i] = cand[i] & {DATA_W{sel[i]}};
  end

  always_comb begin
    out = '0;
    for (int i = 0; i < OP_N; i++) out = out | masked[i];
  end

  always_comb begin
    if (sel == '0) begin
      a_r11_idle_zero: assert (out == '0)
        else $error("empty select leaked a value");
    end
  end
endmodule

// File: rtl/onehot_alu.sv
module onehot_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = XLEN
) (
  input  logic [OP_N-1:0]   op_sel,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic [DATA_W-1:0] result
);
  localparam int SH_W = $clog2(DATA_W);

  logic                        sub_mode;
  logic [DATA_W-1:0]           arith_sum;
  logic                        lt_s;
  logic                        lt_u;
  logic [DATA_W-1:0]           and_r, nor_r, or_r, xor_r;
  logic [DATA_W-1:0]           shift_r;
  logic [OP_N-1:0][DATA_W-1:0] cand;

  // Everything except a plain add drives the chain as a subtractor.
  assign sub_mode = ~op_sel[OP_ADD];

  alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .sub_mode   (sub_mode),
    .a          (src_a),
    .b          (src_b),
    .sum        (arith_sum),
    .lt_signed  (lt_s),
    .lt_unsigned(lt_u)
  );

  alu_bitwise #(.DATA_W(DATA_W)) u_bitwise (
    .a    (src_a),
    .b    (src_b),
    .and_r(and_r),
    .nor_r(nor_r),
    .or_r (or_r),
    .xor_r(xor_r)
  );

  alu_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shifter (
    .a       (src_a),
    .shamt   (src_b[SH_W-1:0]),
    .dir_left(op_sel[OP_SLL]),
    .arith   (op_sel[OP_SRA]),
    .shifted (shift_r)
  );

  always_comb begin
    cand          = '0;
    cand[OP_ADD]  = arith_sum;
    cand[OP_SUB]  = arith_sum;
    cand[OP_SLT]  = {{(DATA_W-1){1'b0}}, lt_s};
    cand[OP_SLTU] = {{(DATA_W-1){1'b0}}, lt_u};
    cand[OP_AND]  = and_r;
    cand[OP_NOR]  = nor_r;
    cand[OP_OR]   = or_r;
    cand[OP_XOR]  = xor_r;
    cand[OP_SLL]  = shift_r;
    cand[OP_SRL]  = shift_r;
    cand[OP_SRA]  = shift_r;
    cand[OP_LUI]  = src_b;
  end

  alu_result_mux #(.DATA_W(DATA_W), .OP_N(OP_N)) u_mux (
    .sel (op_sel),
    .cand(cand),
    .out (result)
  );

  always_comb begin
    if (op_sel == (OP_N'(1) << OP_SLT) || op_sel == (OP_N'(1) << OP_SLTU)) begin
      a_r3_compare_is_boolean: assert (result[DATA_W-1:1] == '0)
        else $error("compare result not 0 or 1");
    end
    if (op_sel == (OP_N'(1) << OP_LUI)) begin
      a_r10_pass_through: assert (result == src_b)
        else $error("upper immediate altered");
    end
    if (op_sel == (OP_N'(1) << OP_SUB) && src_a == src_b) begin
      a_r2_self_sub_zero: assert (result == '0)
        else $error("x - x not zero");
    end
  end
endmodule

// File: tb/sim_onehot_alu.sv
module sim_onehot_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] op_sel = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [31:0] result;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;  // 50 MHz

  onehot_alu u0 (
    .op_sel(op_sel),
    .src_a (src_a),
    .src_b (src_b),
    .result(result)
  );

  // Reference model written from the requirements.
  function automatic logic [31:0] model(logic [11:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      12'h001: return a + b;
      12'h002: return a - b;
      12'h004: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      12'h008: return (a < b) ? 32'd1 : 32'd0;
      12'h010: return a & b;
      12'h020: return ~(a | b);
      12'h040: return a | b;
      12'h080: return a ^ b;
      12'h100: return a << b[4:0];
      12'h200: return a >> b[4:0];
      12'h400: return $unsigned($signed(a) >>> b[4:0]);
      12'h800: return b;
      default: return 32'h0;
    endcase
  endfunction

  task automatic drive(logic [11:0] op, logic [31:0] a, logic [31:0] b, string tag);
    item_t it;
    @(posedge clk);
    #2;
    op_sel = op;
    src_a  = a;
    src_b  = b;
    it.exp = model(op, a, b);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Same-cycle result (R12): sampled at the falling edge after the drive.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      tests++;
      if (result !== it.exp) begin
        fails++;
        $display("FAIL %s: got %h expected %h", it.tag, result, it.exp);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R11: idle select gives zero, also the state right after reset
    drive(12'h000, 32'hDEAD_BEEF, 32'hFFFF_FFFF, "R11");
    // R1 add, wrap, link address
    drive(12'h001, 32'd7, 32'd35, "R1");
    drive(12'h001, 32'hFFFF_FFFF, 32'd2, "R1");
    drive(12'h001, 32'h1C00_0010, 32'd4, "R1");
    // R2 subtract
    drive(12'h002, 32'd5, 32'd9, "R2");
    drive(12'h002, 32'h8000_0000, 32'd1, "R2");
    drive(12'h002, 32'h1234_5678, 32'h1234_5678, "R2");
    // R3 signed compare
    drive(12'h004, 32'h8000_0000, 32'd1, "R3");
    drive(12'h004, 32'd1, 32'h8000_0000, "R3");
    drive(12'h004, 32'h7FFF_FFFF, 32'h8000_0000, "R3");
    drive(12'h004, 32'hFFFF_FFFE, 32'hFFFF_FFFF, "R3");
    drive(12'h004, 32'd3, 32'd3, "R3");
    // R4 unsigned compare
    drive(12'h008, 32'h8000_0000, 32'd1, "R4");
    drive(12'h008, 32'd1, 32'h8000_0000, "R4");
    drive(12'h008, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R4");
    drive(12'h008, 32'd0, 32'd1, "R4");
    // R5 bitwise
    drive(12'h010, 32'hF0F0_1234, 32'h0FF0_FF00, "R5");
    drive(12'h020, 32'hF0F0_1234, 32'h0FF0_FF00, "R5");
    drive(12'h040, 32'hF0F0_1234, 32'h0FF0_FF00, "R5");
    drive(12'h080, 32'hF0F0_1234, 32'h0FF0_FF00, "R5");
    // R6 left shift
    drive(12'h100, 32'h8000_0001, 32'd0, "R6");
    drive(12'h100, 32'h0000_0003, 32'd31, "R6");
    drive(12'h100, 32'h1234_5678, 32'd4, "R6");
    // R7 logical right shift
    drive(12'h200, 32'h8000_0000, 32'd31, "R7");
    drive(12'h200, 32'hF000_000F, 32'd4, "R7");
    // R8 arithmetic right shift
    drive(12'h400, 32'h8000_0000, 32'd31, "R8");
    drive(12'h400, 32'hF000_000F, 32'd4, "R8");
    drive(12'h400, 32'h7000_000F, 32'd4, "R8");
    // R9 upper bits of B ignored by shifts
    drive(12'h100, 32'h0000_00FF, 32'hFFFF_FFE3, "R9");
    drive(12'h200, 32'hFF00_0000, 32'h8000_0028, "R9");
    drive(12'h400, 32'h8000_0000, 32'h0000_0020, "R9");
    // R10 pass-through
    drive(12'h800, 32'hFFFF_FFFF, 32'hABCDE_000, "R10");
    drive(12'h800, 32'h0, 32'h0000_0000, "R10");
    // R11 again after activity
    drive(12'h000, 32'hFFFF_FFFF, 32'h0000_0001, "R11");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule